// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller decides which power mode a small microcontroller is in and what each on-chip subsystem does in that mode. The CPU asks for a light sleep (wait) or a deep sleep (stop) with single-cycle request pulses. An enabled, unmasked interrupt brings the device back to run. A debug port can also act on the controller. It has a debug-enable level and single-cycle "enter background" and "resume" pulses.

From the registered mode the controller drives one enable bit per subsystem, where 1 means on and 0 means standby. It also drives a regulator select (full or loose), an I/O hold line, a CPU clock enable and a pulse that clears the CPU interrupt mask when the device sleeps. A busy flag tells the debug port that memory-access commands must be refused with an error. Four keep-on configuration bits, and the debug enable, are captured when stop is entered.

Top module: `pm_seq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first request after it, the mode is run (code 0), all 15 enables are 1, the regulator is full (1), I/O hold is 0, the CPU clock enable is 1, the busy flag is 0 and the mask-clear pulse is 0.
- R2: A wait request in run gives, on the next clock, mode code 1 with all enables 1 except bit 2 (CPU) and bit 4 (RAM), i.e. 0x7FEB. The regulator stays full, I/O hold stays 0, the CPU clock enable goes to 0 and the mask-clear pulse is 1 for exactly that one cycle.
- R3: A stop request in run gives, on the next clock, mode code 2 with a loose regulator (0), I/O hold 1, the CPU clock enable 0 and a one-cycle mask-clear pulse. A stop request wins over a wait request in the same cycle.
- R4: In stop, enable bits 1, 5, 6 and 9 equal keep-on bits 0, 1, 2 and 3 as sampled at stop entry. All other bits are 0 except bit 10. Later changes to the keep-on bits have no effect until the next stop entry.
- R5: If the debug enable is 1 when stop is entered, enable bit 10 (debug) stays 1 and the regulator stays full for the whole stop period, even if the debug enable falls during stop.
- R6: An interrupt in wait or stop gives mode run with all enables on at the next clock. The CPU clock enable rises one clock later.
- R7: In wait, a wait request or a stop request is ignored. In stop, wait and stop requests are ignored.
- R8: The busy flag is 1 exactly when the registered mode is wait or stop.
- R9: A background command while the debug enable is 1, in run or in stop, gives mode code 3 at the next clock, with all enables on, full regulation and I/O hold 0. The clock enable follows the R6 lag when leaving stop. Without the debug enable, or in wait, the command is ignored.
- R10: In stop, a background command beats a simultaneous interrupt. In background mode, sleep requests are ignored, and a resume pulse returns to run at the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_req | input | 1 | Light-sleep request pulse from the CPU |
| stop_req | input | 1 | Deep-sleep request pulse from the CPU |
| irq_pend | input | 1 | An enabled, unmasked interrupt is pending |
| bdm_en | input | 1 | Debug-enable level from the debug port |
| bkgd_cmd | input | 1 | Enter-background command pulse |
| bkgd_go | input | 1 | Resume-from-background pulse |
| keep_on_cfg | input | 4 | Keep-on bits for low-power oscillator, ADC, comparator, watchdog |
| mode_o | output | 2 | Mode code: 0 run, 1 wait, 2 stop, 3 background |
| sub_en_o | output | 15 | Per-subsystem enables (1 on, 0 standby) |
| reg_full_o | output | 1 | Regulator select: 1 full, 0 loose |
| io_hold_o | output | 1 | Pins hold their state |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| lp_busy_o | output | 1 | Debug memory access must return a low-power error |
| imask_clr_o | output | 1 | Clear the CPU interrupt-mask bit |

## Verification
The hardest case to reach is a stop period where the debug enable was sampled high at entry and then falls. After that, a background command is offered with the enable low and must be ignored, while bit 10 and full regulation must stay put. The bench gets there with a stop entry that has the debug enable high and all keep-on bits low. It then drops the enable, sends a background command, raises the enable again and sends a background command together with an interrupt, which exercises the priority rule. The keep-on capture is covered the same way: the bits are changed on purpose in the middle of a stop period.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int NUM_SUB = 15;
    localparam int NUM_OPT = 4;

    localparam int SUB_CLKGEN  = 0;
    localparam int SUB_LPOSC   = 1;
    localparam int SUB_CPU     = 2;
    localparam int SUB_FLASH   = 3;
    localparam int SUB_RAM     = 4;
    localparam int SUB_ADC     = 5;
    localparam int SUB_CMP     = 6;
    localparam int SUB_SERIAL  = 7;
    localparam int SUB_TIMER   = 8;
    localparam int SUB_WDOG    = 9;
    localparam int SUB_DEBUG   = 10;
    localparam int SUB_INTCTL  = 11;
    localparam int SUB_LVDET   = 12;
    localparam int SUB_GATEDRV = 13;
    localparam int SUB_DELAY   = 14;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_WAIT = 2'd1,
        PM_STOP = 2'd2,
        PM_BKGD = 2'd3
    } pm_mode_e;

    typedef enum logic [1:0] {
        POL_ON   = 2'd0,
        POL_STBY = 2'd1,
        POL_OPT  = 2'd2,
        POL_DBG  = 2'd3
    } pol_e;

    typedef struct packed {
        pm_mode_e             mode;
        logic [NUM_OPT-1:0]   opt;
        logic                 bdm;
        logic                 iclr;
    } fsm_state_t;

    function automatic pol_e wait_pol(input int idx);
        if (idx == SUB_CPU || idx == SUB_RAM) return POL_STBY;
        return POL_ON;
    endfunction

    function automatic pol_e stop_pol(input int idx);
        case (idx)
            SUB_LPOSC, SUB_ADC, SUB_CMP, SUB_WDOG: return POL_OPT;
            SUB_DEBUG:                             return POL_DBG;
            default:                               return POL_STBY;
        endcase
    endfunction

    function automatic int opt_slot(input int idx);
        case (idx)
            SUB_LPOSC: return 0;
            SUB_ADC:   return 1;
            SUB_CMP:   return 2;
            SUB_WDOG:  return 3;
            default:   return 0;
        endcase
    endfunction

    function automatic logic is_low_power(input pm_mode_e m);
        return (m == PM_WAIT) || (m == PM_STOP);
    endfunction

endpackage

// File: rtl/pm_mode_fsm.sv
module pm_mode_fsm
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_req,
    input  logic               stop_req,
    input  logic               irq_pend,
    input  logic               bdm_en,
    input  logic               bkgd_cmd,
    input  logic               bkgd_go,
    input  logic [NUM_OPT-1:0] keep_on_cfg,
    output pm_mode_e           mode_q_o,
    output pm_mode_e           mode_d_o,
    output logic [NUM_OPT-1:0] opt_lat_o,
    output logic               bdm_lat_o,
    output logic               iclr_o
);

    fsm_state_t state_d, state_q;
    logic       dbg_entry;

    assign dbg_entry = bkgd_cmd && bdm_en;

    always_comb begin
        state_d      = state_q;
        state_d.iclr = 1'b0;
        unique case (state_q.mode)
            PM_RUN: begin
                if (dbg_entry) begin
                    state_d.mode = PM_BKGD;
                end else if (stop_req) begin
                    state_d.mode = PM_STOP;
                    state_d.opt  = keep_on_cfg;
                    state_d.bdm  = bdm_en;
                    state_d.iclr = 1'b1;
                end else if (wait_req) begin
                    state_d.mode = PM_WAIT;
                    state_d.iclr = 1'b1;
                end
            end
            PM_WAIT: begin
                if (irq_pend) state_d.mode = PM_RUN;
            end
            PM_STOP: begin
                if (dbg_entry)     state_d.mode = PM_BKGD;
                else if (irq_pend) state_d.mode = PM_RUN;
            end
            PM_BKGD: begin
                if (bkgd_go) state_d.mode = PM_RUN;
            end
            default: state_d.mode = PM_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.mode <= PM_RUN;
            state_q.opt  <= '0;
            state_q.bdm  <= 1'b0;
            state_q.iclr <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_q_o  = state_q.mode;
    assign mode_d_o  = state_d.mode;
    assign opt_lat_o = state_q.opt;
    assign bdm_lat_o = state_q.bdm;
    assign iclr_o    = state_q.iclr;

    // R7: wait never leads straight to stop
    a_r7_wait_not_to_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == PM_WAIT) |=> (state_q.mode != PM_STOP));

    // R4 / R5: captured configuration is frozen while stop lasts
    a_r4_opt_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == PM_STOP) && ($past(state_q.mode) == PM_STOP)
        |-> $stable(state_q.opt) && $stable(state_q.bdm));

    // R2 / R3: mask-clear pulse only on a fresh entry from run
    a_r2_iclr_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.iclr |-> is_low_power(state_q.mode) && ($past(state_q.mode) == PM_RUN));

    // R10: background mode is left only for run
    a_r10_bkgd_exit_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.mode == PM_BKGD) |=> (state_q.mode == PM_BKGD) || (state_q.mode == PM_RUN));

endmodule

// File: rtl/pm_enable_map.sv
module pm_enable_map
    import pm_pkg::*;
(
    input  pm_mode_e           mode,
    input  logic [NUM_OPT-1:0] opt_lat,
    input  logic               bdm_lat,
    output logic [NUM_SUB-1:0] sub_en,
    output logic               reg_full,
    output logic               io_hold
);

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_sub
        localparam pol_e WPOL = wait_pol(i);
        localparam pol_e SPOL = stop_pol(i);
        localparam int   SLOT = opt_slot(i);
        logic bit_en;

        always_comb begin
            bit_en = 1'b1;
            unique case (mode)
                PM_WAIT: bit_en = (WPOL == POL_ON);
                PM_STOP: begin
                    unique case (SPOL)
                        POL_ON:   bit_en = 1'b1;
                        POL_OPT:  bit_en = opt_lat[SLOT];
                        POL_DBG:  bit_en = bdm_lat;
                        default:  bit_en = 1'b0;
                    endcase
                end
                default: bit_en = 1'b1;
            endcase
        end

        assign sub_en[i] = bit_en;
    end

    always_comb begin
        reg_full = 1'b1;
        io_hold  = 1'b0;
        if (mode == PM_STOP) begin
            reg_full = bdm_lat;
            io_hold  = 1'b1;
        end
    end

endmodule

// File: rtl/pm_clk_seq.sv
module pm_clk_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic lp_now,
    input  logic lp_next,
    output logic cpu_clk_en
);

    logic clk_en_d, clk_en_q;

    always_comb begin
        if (lp_next)      clk_en_d = 1'b0;
        else if (lp_now)  clk_en_d = 1'b0;
        else              clk_en_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_en_q <= 1'b1;
        else        clk_en_q <= clk_en_d;
    end

    assign cpu_clk_en = clk_en_q;

    // R2 / R3: clock gated for the whole low-power period
    a_r2_gated_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
        lp_now |-> !clk_en_q);

    // R6: one cycle of lag between wake and clock restart
    a_r6_clk_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_now) |-> !clk_en_q);

    // R6: clock returns on the cycle after the lag
    a_r6_clk_back: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lp_now) && !lp_now |=> lp_now || clk_en_q);

endmodule

// File: rtl/pm_seq_ctrl.sv
module pm_seq_ctrl
    import pm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wait_req,
    input  logic               stop_req,
    input  logic               irq_pend,
    input  logic               bdm_en,
    input  logic               bkgd_cmd,
    input  logic               bkgd_go,
    input  logic [NUM_OPT-1:0] keep_on_cfg,
    output logic [1:0]         mode_o,
    output logic [NUM_SUB-1:0] sub_en_o,
    output logic               reg_full_o,
    output logic               io_hold_o,
    output logic               cpu_clk_en_o,
    output logic               lp_busy_o,
    output logic               imask_clr_o
);

    pm_mode_e           mode_q, mode_d;
    logic [NUM_OPT-1:0] opt_lat;
    logic               bdm_lat;

    pm_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wait_req    (wait_req),
        .stop_req    (stop_req),
        .irq_pend    (irq_pend),
        .bdm_en      (bdm_en),
        .bkgd_cmd    (bkgd_cmd),
        .bkgd_go     (bkgd_go),
        .keep_on_cfg (keep_on_cfg),
        .mode_q_o    (mode_q),
        .mode_d_o    (mode_d),
        .opt_lat_o   (opt_lat),
        .bdm_lat_o   (bdm_lat),
        .iclr_o      (imask_clr_o)
    );

    pm_enable_map u_map (
        .mode     (mode_q),
        .opt_lat  (opt_lat),
        .bdm_lat  (bdm_lat),
        .sub_en   (sub_en_o),
        .reg_full (reg_full_o),
        .io_hold  (io_hold_o)
    );

    pm_clk_seq u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .lp_now     (is_low_power(mode_q)),
        .lp_next    (is_low_power(mode_d)),
        .cpu_clk_en (cpu_clk_en_o)
    );

    assign mode_o    = mode_q;
    assign lp_busy_o = is_low_power(mode_q);

    // R1 / R6: out of sleep every subsystem runs
    a_r6_awake_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        !lp_busy_o |-> (&sub_en_o) && reg_full_o && !io_hold_o);

    // R3: pins held only in deep sleep, and then the CPU is in standby
    a_r3_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
        io_hold_o |-> (mode_o == 2'd2) && !sub_en_o[SUB_CPU] && !cpu_clk_en_o);

    // R5: loose regulation implies the debug clock is off
    a_r5_loose_no_dbg: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_full_o |-> !sub_en_o[SUB_DEBUG]);

endmodule

// File: tb/sim_pm_seq_ctrl.sv
module sim_pm_seq_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [14:0] EN_ALL  = 15'h7FFF;
    localparam logic [14:0] EN_WAIT = 15'h7FEB;

    typedef struct {
        string       tag;
        logic [1:0]  mode;
        logic [14:0] en;
        logic        rf;
        logic        hold;
        logic        ck;
        logic        busy;
        logic        iclr;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wait_req = 0, stop_req = 0, irq_pend = 0, bdm_en = 0, bkgd_cmd = 0, bkgd_go = 0;
    logic [3:0] keep_on_cfg = '0;
    logic [1:0] mode_o;
    logic [14:0] sub_en_o;
    logic reg_full_o, io_hold_o, cpu_clk_en_o, lp_busy_o, imask_clr_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_seq_ctrl u0 (.*);

    function automatic exp_t mk(string tag, logic [1:0] m, logic [14:0] en, logic rf,
                                logic hold, logic ck, logic busy, logic iclr);
        exp_t e;
        e.tag = tag; e.mode = m; e.en = en; e.rf = rf; e.hold = hold;
        e.ck = ck; e.busy = busy; e.iclr = iclr;
        return e;
    endfunction

    function automatic logic [14:0] stop_en(logic [3:0] opt, logic bdm);
        logic [14:0] e = '0;
        e[1] = opt[0]; e[5] = opt[1]; e[6] = opt[2]; e[9] = opt[3]; e[10] = bdm;
        return e;
    endfunction

    task automatic compare(exp_t e);
        n_cmp++;
        if (mode_o !== e.mode || sub_en_o !== e.en || reg_full_o !== e.rf ||
            io_hold_o !== e.hold || cpu_clk_en_o !== e.ck || lp_busy_o !== e.busy ||
            imask_clr_o !== e.iclr) begin
            n_bad++;
            $display("FAIL %s: got mode=%0d en=%h rf=%b hold=%b ck=%b busy=%b iclr=%b exp mode=%0d en=%h rf=%b hold=%b ck=%b busy=%b iclr=%b",
                     e.tag, mode_o, sub_en_o, reg_full_o, io_hold_o, cpu_clk_en_o, lp_busy_o, imask_clr_o,
                     e.mode, e.en, e.rf, e.hold, e.ck, e.busy, e.iclr);
        end
    endtask

    // driver: inputs are already set; push expectation for after next edge
    task automatic chk(exp_t e);
        q.push_back(e);
        @(negedge clk);
        wait_req = 0; stop_req = 0; irq_pend = 0; bkgd_cmd = 0; bkgd_go = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(mk("R1 reset", 0, EN_ALL, 1, 0, 1, 0, 0));
        rst_n = 1;
        @(negedge clk);
        compare(mk("R1 after reset", 0, EN_ALL, 1, 0, 1, 0, 0));

        wait_req = 1;   chk(mk("R2 wait entry", 1, EN_WAIT, 1, 0, 0, 1, 1));
        wait_req = 1;   chk(mk("R7 wait in wait", 1, EN_WAIT, 1, 0, 0, 1, 0));
        stop_req = 1;   chk(mk("R7 stop in wait R8", 1, EN_WAIT, 1, 0, 0, 1, 0));
        bdm_en = 1; bkgd_cmd = 1; chk(mk("R9 bkgd in wait", 1, EN_WAIT, 1, 0, 0, 1, 0));
        bdm_en = 0;
        irq_pend = 1;   chk(mk("R6 wake wait", 0, EN_ALL, 1, 0, 0, 0, 0));
        chk(mk("R6 clk back", 0, EN_ALL, 1, 0, 1, 0, 0));

        keep_on_cfg = 4'b0101;
        stop_req = 1;   chk(mk("R3 stop entry", 2, stop_en(4'b0101, 0), 0, 1, 0, 1, 1));
        keep_on_cfg = 4'b1010;
        chk(mk("R4 cfg change ignored", 2, stop_en(4'b0101, 0), 0, 1, 0, 1, 0));
        wait_req = 1;   chk(mk("R7 wait in stop", 2, stop_en(4'b0101, 0), 0, 1, 0, 1, 0));
        bkgd_cmd = 1;   chk(mk("R9 bkgd no enable", 2, stop_en(4'b0101, 0), 0, 1, 0, 1, 0));
        irq_pend = 1;   chk(mk("R6 wake stop", 0, EN_ALL, 1, 0, 0, 0, 0));
        chk(mk("R6 clk back stop", 0, EN_ALL, 1, 0, 1, 0, 0));

        keep_on_cfg = 4'b0000; bdm_en = 1;
        wait_req = 1; stop_req = 1;
        chk(mk("R3 R5 stop wins, debug kept", 2, stop_en(4'b0000, 1), 1, 1, 0, 1, 1));
        bdm_en = 0;
        chk(mk("R5 debug latched", 2, stop_en(4'b0000, 1), 1, 1, 0, 1, 0));
        bkgd_cmd = 1;   chk(mk("R9 bkgd enable low", 2, stop_en(4'b0000, 1), 1, 1, 0, 1, 0));
        bdm_en = 1; bkgd_cmd = 1; irq_pend = 1;
        chk(mk("R10 R9 bkgd beats irq", 3, EN_ALL, 1, 0, 0, 0, 0));
        chk(mk("R9 bkgd clk lag", 3, EN_ALL, 1, 0, 1, 0, 0));
        wait_req = 1;   chk(mk("R10 wait in bkgd", 3, EN_ALL, 1, 0, 1, 0, 0));
        stop_req = 1;   chk(mk("R10 stop in bkgd", 3, EN_ALL, 1, 0, 1, 0, 0));
        bkgd_go = 1;    chk(mk("R10 resume", 0, EN_ALL, 1, 0, 1, 0, 0));
        bkgd_cmd = 1; stop_req = 1;
        chk(mk("R9 bkgd from run", 3, EN_ALL, 1, 0, 1, 0, 0));
        bkgd_go = 1;    chk(mk("R10 resume again", 0, EN_ALL, 1, 0, 1, 0, 0));
        bdm_en = 0;

        keep_on_cfg = 4'b1111;
        stop_req = 1;   chk(mk("R4 all keep-on", 2, stop_en(4'b1111, 0), 0, 1, 0, 1, 1));
        rst_n = 0;
        #1;
        compare(mk("R1 reset in stop", 0, EN_ALL, 1, 0, 1, 0, 0));
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare(mk("R1 run after reset", 0, EN_ALL, 1, 0, 1, 0, 0));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule